// File: doc/BRIEF.md
# Byte-Valid Write-Merging Line Buffer

This block is a small write-back store of cache lines. Each line carries a valid bit for every one of its bytes. A store slot names one aligned 8-byte word, carries up to eight bytes, and has a byte mask. The slot is merged straight into the buffered line; nothing is read from memory first. Several requesters can therefore write different bytes of one line in any order, and every written byte is kept.

Lines leave the buffer only as eviction records. Each record holds the line address, the full line data and the per-byte valid mask, so the memory side writes only the bytes that are marked. A record is produced for one of two reasons:
- A store needs a new line while every entry is in use. The store stalls and a round-robin victim goes out first.
- A flush command is given. The buffer then drains every occupied line, one per accepted handshake.

A load port reports a hit only when every byte it asks for is held in the buffer. The answer comes one cycle later.

Top module: `bytemerge_line_buffer`

## Requirements
- R1: Each line records validity per byte. The eviction mask has bit `8*w+i` set exactly when some accepted store to word `w` of that line had byte-mask bit `i` set since the line was last emptied.
- R2: A store to a line that is already held, or to a new line while a free entry exists, is accepted in the cycle it is presented (`st_ready` high). No eviction record is raised for it.
- R3: Outside a flush, `ev_valid` stays low except when a store is waiting for an entry and none is free. Stores are held in the buffer, not forwarded.
- R4: Stores to different bytes of the same line are merged. All of their bytes appear in later load data and in the eviction record.
- R5: When two accepted stores write the same byte, the byte holds the value of the later one.
- R6: Word address bits `[2:0]` of `st_word_addr` select word `w` of the 64-byte line. Byte `i` of `st_data` (bits `8i+7:8i`) lands in line byte `8*w+i`, which is bits `64w+8i+7 : 64w+8i` of `ev_data`.
- R7: An eviction record carries the line address (byte address divided by 64) and the line data. The bytes whose mask bits are set hold the merged store values, and the mask is never zero.
- R8: A load answers in the next cycle with `ld_rsp_valid`. `ld_hit` is 1 only if the line is held and every byte selected by `ld_be` is valid. On a hit, `ld_data` carries the requested bytes and zeros in the others; on a miss it is all zero. A load never changes the buffer.
- R9: A `flush_req` pulse raises `flush_busy` from the next cycle. One cycle later, every occupied line is offered in turn and cleared on its handshake. `flush_busy` falls one cycle after the buffer is empty, and `st_ready` is low throughout.
- R10: A store to a new line while all entries are occupied holds `st_ready` low. The block raises an eviction of an occupied victim, and the store is accepted after that eviction completes. A store and an eviction never complete in the same cycle.
- R11: While `ev_valid` is high and `ev_ready` is low, `ev_valid`, `ev_line_addr` and `ev_mask` hold steady.
- R12: After reset the buffer is empty, and `ev_valid`, `flush_busy` and `ld_rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store slot presented |
| st_ready | output | 1 | Store slot accepted this cycle |
| st_word_addr | input | ADDR_W-3 | Address of the 8-byte word being stored |
| st_data | input | DATA_W | Store data, byte i in bits 8i+7:8i |
| st_be | input | DATA_W/8 | Store byte mask |
| ld_valid | input | 1 | Load request |
| ld_word_addr | input | ADDR_W-3 | Address of the 8-byte word loaded |
| ld_be | input | DATA_W/8 | Bytes the load needs |
| ld_rsp_valid | output | 1 | Load answer valid, one cycle after the request |
| ld_hit | output | 1 | All requested bytes were valid |
| ld_data | output | DATA_W | Requested bytes on a hit, zero elsewhere |
| flush_req | input | 1 | Pulse: drain all occupied lines |
| flush_busy | output | 1 | A flush is pending or in progress |
| ev_valid | output | 1 | Eviction record offered |
| ev_ready | input | 1 | Memory side takes the record |
| ev_line_addr | output | ADDR_W-6 | Line address of the record |
| ev_data | output | LINE_BYTES*8 | Line data |
| ev_mask | output | LINE_BYTES | Per-byte valid mask |

## Verification
The stability property on the eviction port relies on two conditions for a store held by `st_valid`. First, the requester keeps the slot unchanged until it is accepted. Second, every store byte mask is nonzero, because a store with an empty mask would claim an entry that holds no byte. The bench drives each store as a held request with a nonzero mask and waits for acceptance before it changes anything. It only raises `flush_req` while no store is presented, so a capacity eviction and a flush never compete for the eviction port. Loads, including loads with an empty mask, are issued freely and may coincide with stores. `ev_ready` is driven both held low and toggling at random.

// File: rtl/bmlb_pkg.sv
package bmlb_pkg;

  typedef enum logic [0:0] {
    CTL_RUN   = 1'b0,
    CTL_DRAIN = 1'b1
  } ctl_state_t;

  // index of the lowest set bit (0 when none is set)
  function automatic logic [4:0] low_one(input logic [31:0] v);
    logic [4:0] r;
    r = '0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = 5'(i);
    end
    return r;
  endfunction

  // position of byte b of word w inside a line of words of wb bytes
  function automatic int unsigned lane_pos(input int unsigned w, input int unsigned b,
                                           input int unsigned wb);
    return w * wb + b;
  endfunction

  // next round-robin pointer value
  function automatic int unsigned rr_next(input int unsigned p, input int unsigned n);
    return (p == n - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/bmlb_tag_match.sv
module bmlb_tag_match #(
  parameter int NUM_LINES = 4,
  parameter int TAG_W     = 26
) (
  input  logic [NUM_LINES*TAG_W-1:0] tags_flat,
  input  logic [NUM_LINES-1:0]       occ_vec,
  input  logic [TAG_W-1:0]           key,
  output logic [NUM_LINES-1:0]       match_vec
);

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_cmp
    assign match_vec[g] = occ_vec[g] && (tags_flat[g*TAG_W +: TAG_W] == key);
  end

endmodule

// File: rtl/bmlb_line_store.sv
module bmlb_line_store
  import bmlb_pkg::*;
#(
  parameter int NUM_LINES  = 4,
  parameter int LINE_BYTES = 64,
  parameter int WORD_BYTES = 8,
  parameter int TAG_W      = 26,
  parameter int IDX_W      = 2,
  parameter int WSEL_W     = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  // merge port
  input  logic                        wr_en,
  input  logic                        wr_alloc,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [TAG_W-1:0]            wr_tag,
  input  logic [WSEL_W-1:0]           wr_word,
  input  logic [WORD_BYTES*8-1:0]     wr_data,
  input  logic [WORD_BYTES-1:0]       wr_be,
  // clear port
  input  logic                        clr_en,
  input  logic [IDX_W-1:0]            clr_idx,
  // eviction read
  input  logic [IDX_W-1:0]            ev_idx,
  output logic [TAG_W-1:0]            ev_tag,
  output logic [LINE_BYTES*8-1:0]     ev_data,
  output logic [LINE_BYTES-1:0]       ev_mask,
  // load read
  input  logic [IDX_W-1:0]            ld_idx,
  input  logic [WSEL_W-1:0]           ld_word,
  output logic [WORD_BYTES*8-1:0]     ld_word_data,
  output logic [WORD_BYTES-1:0]       ld_word_mask,
  // lookup view
  output logic [NUM_LINES*TAG_W-1:0]  tags_flat,
  output logic [NUM_LINES-1:0]        occ_vec
);

  logic [TAG_W-1:0]        tag_q  [NUM_LINES];
  logic [LINE_BYTES-1:0]   mask_q [NUM_LINES];
  logic [LINE_BYTES*8-1:0] data_q [NUM_LINES];

  // validity and tags carry reset; data is qualified by the mask
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        tag_q[i]  <= '0;
        mask_q[i] <= '0;
      end
    end else begin
      if (clr_en) begin
        mask_q[clr_idx] <= '0;
      end
      if (wr_en) begin
        if (wr_alloc) tag_q[wr_idx] <= wr_tag;
        for (int b = 0; b < WORD_BYTES; b++) begin
          if (wr_be[b]) begin
            mask_q[wr_idx][lane_pos(int'(wr_word), b, WORD_BYTES)] <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < WORD_BYTES; b++) begin
        if (wr_be[b]) begin
          data_q[wr_idx][lane_pos(int'(wr_word), b, WORD_BYTES)*8 +: 8] <= wr_data[b*8 +: 8];
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_view
    assign occ_vec[g]                     = |mask_q[g];
    assign tags_flat[g*TAG_W +: TAG_W]    = tag_q[g];
  end

  assign ev_tag       = tag_q[ev_idx];
  assign ev_data      = data_q[ev_idx];
  assign ev_mask      = mask_q[ev_idx];
  assign ld_word_data = data_q[ld_idx][int'(ld_word)*WORD_BYTES*8 +: WORD_BYTES*8];
  assign ld_word_mask = mask_q[ld_idx][int'(ld_word)*WORD_BYTES +: WORD_BYTES];

endmodule

// File: rtl/bmlb_ctrl.sv
module bmlb_ctrl
  import bmlb_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int IDX_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             st_valid,
  input  logic             st_hit,
  input  logic             free_any,
  input  logic             any_occ,
  input  logic             flush_req,
  input  logic             ev_ready,
  output logic             st_ready,
  output logic             ev_valid,
  output logic             drain_sel,
  output logic             cap_evict,
  output logic             flush_busy,
  output logic [IDX_W-1:0] victim
);

  ctl_state_t state_q;
  logic       pend_q;

  assign drain_sel  = (state_q == CTL_DRAIN);
  assign cap_evict  = !drain_sel && st_valid && !st_hit && !free_any;
  assign st_ready   = !drain_sel && !pend_q && (st_hit || free_any);
  assign ev_valid   = drain_sel ? any_occ : cap_evict;
  assign flush_busy = pend_q || drain_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CTL_RUN;
      pend_q  <= 1'b0;
    end else begin
      case (state_q)
        CTL_RUN: begin
          if (pend_q && !cap_evict) begin
            state_q <= CTL_DRAIN;
            pend_q  <= 1'b0;
          end else if (flush_req) begin
            pend_q  <= 1'b1;
          end
        end
        default: begin
          if (!any_occ) state_q <= CTL_RUN;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      victim <= '0;
    end else if (cap_evict && ev_ready) begin
      victim <= IDX_W'(rr_next(int'(victim), NUM_LINES));
    end
  end

endmodule

// File: rtl/bytemerge_line_buffer.sv
module bytemerge_line_buffer
  import bmlb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int LINE_BYTES = 64,
  parameter int NUM_LINES  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      st_valid,
  output logic                      st_ready,
  input  logic [ADDR_W-4:0]         st_word_addr,
  input  logic [DATA_W-1:0]         st_data,
  input  logic [DATA_W/8-1:0]       st_be,
  input  logic                      ld_valid,
  input  logic [ADDR_W-4:0]         ld_word_addr,
  input  logic [DATA_W/8-1:0]       ld_be,
  output logic                      ld_rsp_valid,
  output logic                      ld_hit,
  output logic [DATA_W-1:0]         ld_data,
  input  logic                      flush_req,
  output logic                      flush_busy,
  output logic                      ev_valid,
  input  logic                      ev_ready,
  output logic [ADDR_W-7:0]         ev_line_addr,
  output logic [LINE_BYTES*8-1:0]   ev_data,
  output logic [LINE_BYTES-1:0]     ev_mask
);

  localparam int WORD_BYTES = DATA_W / 8;
  localparam int WORDS      = LINE_BYTES / WORD_BYTES;
  localparam int WSEL_W     = $clog2(WORDS);
  localparam int TAG_W      = ADDR_W - $clog2(LINE_BYTES);
  localparam int IDX_W      = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  // address split
  logic [TAG_W-1:0]  st_tag, ld_tag;
  logic [WSEL_W-1:0] st_word, ld_word;
  assign st_tag  = st_word_addr[ADDR_W-4 -: TAG_W];
  assign st_word = st_word_addr[WSEL_W-1:0];
  assign ld_tag  = ld_word_addr[ADDR_W-4 -: TAG_W];
  assign ld_word = ld_word_addr[WSEL_W-1:0];

  // named internal events (observed by the checker)
  logic [NUM_LINES-1:0]       st_match_vec, ld_match_vec, occ_vec;
  logic [NUM_LINES*TAG_W-1:0] tags_flat;
  logic                       st_fire, ev_fire, cap_evict, drain_sel;
  logic [IDX_W-1:0]           victim, st_idx, alloc_idx, drain_idx, ev_idx, ld_idx;
  logic                       st_hit, free_any, any_occ;

  bmlb_tag_match #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_st_match (
    .tags_flat (tags_flat),
    .occ_vec   (occ_vec),
    .key       (st_tag),
    .match_vec (st_match_vec)
  );

  bmlb_tag_match #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_ld_match (
    .tags_flat (tags_flat),
    .occ_vec   (occ_vec),
    .key       (ld_tag),
    .match_vec (ld_match_vec)
  );

  assign st_hit    = |st_match_vec;
  assign free_any  = ~&occ_vec;
  assign any_occ   = |occ_vec;
  assign alloc_idx = IDX_W'(low_one(32'(~occ_vec)));
  assign st_idx    = st_hit ? IDX_W'(low_one(32'(st_match_vec))) : alloc_idx;
  assign drain_idx = IDX_W'(low_one(32'(occ_vec)));
  assign ld_idx    = IDX_W'(low_one(32'(ld_match_vec)));

  bmlb_ctrl #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_valid   (st_valid),
    .st_hit     (st_hit),
    .free_any   (free_any),
    .any_occ    (any_occ),
    .flush_req  (flush_req),
    .ev_ready   (ev_ready),
    .st_ready   (st_ready),
    .ev_valid   (ev_valid),
    .drain_sel  (drain_sel),
    .cap_evict  (cap_evict),
    .flush_busy (flush_busy),
    .victim     (victim)
  );

  assign ev_idx  = drain_sel ? drain_idx : victim;
  assign st_fire = st_valid && st_ready;
  assign ev_fire = ev_valid && ev_ready;

  logic [WORD_BYTES*8-1:0] ld_word_data;
  logic [WORD_BYTES-1:0]   ld_word_mask;

  bmlb_line_store #(
    .NUM_LINES  (NUM_LINES),
    .LINE_BYTES (LINE_BYTES),
    .WORD_BYTES (WORD_BYTES),
    .TAG_W      (TAG_W),
    .IDX_W      (IDX_W),
    .WSEL_W     (WSEL_W)
  ) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (st_fire),
    .wr_alloc     (!st_hit),
    .wr_idx       (st_idx),
    .wr_tag       (st_tag),
    .wr_word      (st_word),
    .wr_data      (st_data),
    .wr_be        (st_be),
    .clr_en       (ev_fire),
    .clr_idx      (ev_idx),
    .ev_idx       (ev_idx),
    .ev_tag       (ev_line_addr),
    .ev_data      (ev_data),
    .ev_mask      (ev_mask),
    .ld_idx       (ld_idx),
    .ld_word      (ld_word),
    .ld_word_data (ld_word_data),
    .ld_word_mask (ld_word_mask),
    .tags_flat    (tags_flat),
    .occ_vec      (occ_vec)
  );

  // load answer: registered, requested bytes only
  logic                ld_hit_c;
  logic [DATA_W-1:0]   ld_sel_data;
  assign ld_hit_c = (|ld_match_vec) && ((ld_word_mask & ld_be) == ld_be);

  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_ldsel
    assign ld_sel_data[g*8 +: 8] = ld_be[g] ? ld_word_data[g*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_rsp_valid <= 1'b0;
      ld_hit       <= 1'b0;
      ld_data      <= '0;
    end else begin
      ld_rsp_valid <= ld_valid;
      ld_hit       <= ld_valid && ld_hit_c;
      ld_data      <= (ld_valid && ld_hit_c) ? ld_sel_data : '0;
    end
  end

endmodule

// File: rtl/bytemerge_line_buffer_chk.sv
module bytemerge_line_buffer_chk #(
  parameter int NUM_LINES  = 4,
  parameter int LINE_BYTES = 64,
  parameter int TAG_W      = 26,
  parameter int DATA_W     = 64
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  st_valid,
  input logic                  st_ready,
  input logic                  ld_valid,
  input logic                  ld_rsp_valid,
  input logic                  ld_hit,
  input logic [DATA_W-1:0]     ld_data,
  input logic                  flush_busy,
  input logic                  ev_valid,
  input logic                  ev_ready,
  input logic [TAG_W-1:0]      ev_line_addr,
  input logic [LINE_BYTES-1:0] ev_mask,
  input logic [NUM_LINES-1:0]  st_match_vec,
  input logic                  st_fire,
  input logic                  ev_fire
);

  AST_ST_EV_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_fire && ev_fire)); // R10

  AST_EV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && !ev_ready |=> ev_valid && $stable(ev_line_addr) && $stable(ev_mask)); // R11

  AST_EV_MASK_NZ: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> ev_mask != '0); // R7

  AST_FLUSH_BLOCKS_ST: assert property (@(posedge clk) disable iff (!rst_n)
    flush_busy |-> !st_ready); // R9

  AST_LD_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> ld_rsp_valid); // R8

  AST_LD_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ld_rsp_valid && !ld_hit |-> ld_data == '0); // R8

  AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(st_match_vec)); // R4

  AST_WB_NO_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && !flush_busy |-> st_valid && !st_ready); // R3

endmodule

bind bytemerge_line_buffer bytemerge_line_buffer_chk #(
  .NUM_LINES  (NUM_LINES),
  .LINE_BYTES (LINE_BYTES),
  .TAG_W      (TAG_W),
  .DATA_W     (DATA_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .st_valid     (st_valid),
  .st_ready     (st_ready),
  .ld_valid     (ld_valid),
  .ld_rsp_valid (ld_rsp_valid),
  .ld_hit       (ld_hit),
  .ld_data      (ld_data),
  .flush_busy   (flush_busy),
  .ev_valid     (ev_valid),
  .ev_ready     (ev_ready),
  .ev_line_addr (ev_line_addr),
  .ev_mask      (ev_mask),
  .st_match_vec (st_match_vec),
  .st_fire      (st_fire),
  .ev_fire      (ev_fire)
);

// File: tb/bytemerge_line_buffer_tb.sv
module bytemerge_line_buffer_tb;

  localparam int NL = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         st_valid = 1'b0;
  logic         st_ready;
  logic [28:0]  st_word_addr = '0;
  logic [63:0]  st_data = '0;
  logic [7:0]   st_be = '0;
  logic         ld_valid = 1'b0;
  logic [28:0]  ld_word_addr = '0;
  logic [7:0]   ld_be = '0;
  logic         ld_rsp_valid, ld_hit;
  logic [63:0]  ld_data;
  logic         flush_req = 1'b0;
  logic         flush_busy;
  logic         ev_valid;
  logic         ev_ready = 1'b1;
  logic [25:0]  ev_line_addr;
  logic [511:0] ev_data;
  logic [63:0]  ev_mask;

  always #10 clk = ~clk;

  bytemerge_line_buffer u_dut (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_word_addr(st_word_addr),
    .st_data(st_data), .st_be(st_be),
    .ld_valid(ld_valid), .ld_word_addr(ld_word_addr), .ld_be(ld_be),
    .ld_rsp_valid(ld_rsp_valid), .ld_hit(ld_hit), .ld_data(ld_data),
    .flush_req(flush_req), .flush_busy(flush_busy),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_line_addr(ev_line_addr),
    .ev_data(ev_data), .ev_mask(ev_mask)
  );

  // reference model: line address -> mask / data
  logic [63:0]  m_mask [int unsigned];
  logic [511:0] m_data [int unsigned];

  int total = 0, bad = 0;
  int phase = 0;            // 0 idle, 1 flush pending, 2 draining
  bit rand_rdy = 0;
  int hold_low = 0;
  bit st_fired = 0;
  bit ld_pend = 0;
  bit exp_hit = 0;
  logic [63:0] exp_ld = '0;
  bit prev_stall = 0;
  logic [25:0] prev_addr = '0;
  logic [63:0] prev_mask = '0;
  int evict_cnt = 0;
  int wd = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    int unsigned k;
    int cnt;
    bit present, exp_ev, exp_rdy;
    #1;
    // R8: answer for last cycle's load
    if (ld_pend) begin
      check(ld_rsp_valid == 1'b1, "R8 rsp_valid", 64'(ld_rsp_valid), 64'd1);
      check(ld_hit == exp_hit, "R8 hit", 64'(ld_hit), 64'(exp_hit));
      check(ld_data == exp_ld, "R8/R4/R5/R6 data", ld_data, exp_ld);
    end else begin
      check(ld_rsp_valid == 1'b0, "R8 no rsp", 64'(ld_rsp_valid), 64'd0);
    end
    ld_pend = 0;
    check(flush_busy == (phase != 0), "R9 busy", 64'(flush_busy), 64'(phase != 0));
    cnt = m_mask.num();
    k = int'(st_word_addr >> 3);
    present = m_mask.exists(k);
    if (phase == 2)      exp_ev = (cnt > 0);
    else if (phase == 1) exp_ev = 0;
    else                 exp_ev = st_valid && !present && (cnt == NL);
    check(ev_valid == exp_ev, (phase != 0) ? "R9 ev_valid" : "R3 ev_valid",
          64'(ev_valid), 64'(exp_ev));
    if (st_valid) begin
      exp_rdy = (phase == 0) && (present || cnt < NL);
      check(st_ready == exp_rdy, (present || cnt < NL) ? "R2 st_ready" : "R10 st_ready",
            64'(st_ready), 64'(exp_rdy));
    end
    if (prev_stall) begin
      check(ev_valid && ev_line_addr == prev_addr && ev_mask == prev_mask, "R11 hold",
            {38'd0, ev_line_addr}, {38'd0, prev_addr});
    end
    // load expectation uses the state before this cycle's store
    if (ld_valid) begin
      int unsigned lk;
      int w;
      lk = int'(ld_word_addr >> 3);
      w = int'(ld_word_addr[2:0]);
      exp_hit = 0;
      exp_ld = '0;
      if (m_mask.exists(lk) && ((m_mask[lk][w*8 +: 8] & ld_be) == ld_be)) begin
        exp_hit = 1;
        for (int b = 0; b < 8; b++)
          if (ld_be[b]) exp_ld[b*8 +: 8] = m_data[lk][(w*8+b)*8 +: 8];
      end
      ld_pend = 1;
    end
    // eviction record
    if (ev_valid && ev_ready) begin
      int unsigned ek;
      ek = int'(ev_line_addr);
      evict_cnt++;
      check(m_mask.exists(ek), "R7 addr held", {38'd0, ev_line_addr}, {38'd0, ev_line_addr});
      if (m_mask.exists(ek)) begin
        logic [63:0] wrong;
        check(ev_mask == m_mask[ek], "R1 mask", ev_mask, m_mask[ek]);
        wrong = '0;
        for (int b = 0; b < 64; b++)
          if (m_mask[ek][b] && ev_data[b*8 +: 8] != m_data[ek][b*8 +: 8]) wrong[b] = 1'b1;
        check(wrong == '0, "R7 data bytes", wrong, 64'd0);
        m_mask.delete(ek);
        m_data.delete(ek);
      end
    end
    // accepted store
    st_fired = st_valid && st_ready;
    if (st_fired) begin
      logic [63:0]  mk;
      logic [511:0] dt;
      int w;
      w = int'(st_word_addr[2:0]);
      mk = present ? m_mask[k] : '0;
      dt = present ? m_data[k] : '0;
      for (int b = 0; b < 8; b++)
        if (st_be[b]) begin
          mk[w*8+b] = 1'b1;
          dt[(w*8+b)*8 +: 8] = st_data[b*8 +: 8];
        end
      m_mask[k] = mk;
      m_data[k] = dt;
    end
    prev_stall = ev_valid && !ev_ready;
    prev_addr  = ev_line_addr;
    prev_mask  = ev_mask;
    if (phase == 0 && flush_req) phase = 1;
    else if (phase == 1)         phase = 2;
    else if (phase == 2 && cnt == 0) phase = 0;
    @(negedge clk);
    if (hold_low > 0) begin
      ev_ready = 1'b0;
      hold_low--;
    end else begin
      ev_ready = rand_rdy ? (($urandom % 3) != 0) : 1'b1;
    end
  endtask

  task automatic do_store(input logic [31:0] a, input logic [63:0] d, input logic [7:0] be);
    st_valid = 1; st_word_addr = a[31:3]; st_data = d; st_be = be;
    do tick(); while (!st_fired);
    st_valid = 0;
  endtask

  task automatic do_load(input logic [31:0] a, input logic [7:0] be);
    ld_valid = 1; ld_word_addr = a[31:3]; ld_be = be;
    tick();
    ld_valid = 0;
  endtask

  task automatic do_flush();
    flush_req = 1;
    tick();
    flush_req = 0;
    do tick(); while (phase != 0);
    check(m_mask.num() == 0, "R9 empty", 64'(m_mask.num()), 64'd0);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<150000", wd);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  localparam logic [31:0] A = 32'h0000_1000;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check(ev_valid == 0, "R12 ev_valid", 64'(ev_valid), 64'd0);
    check(flush_busy == 0, "R12 flush_busy", 64'(flush_busy), 64'd0);
    check(ld_rsp_valid == 0, "R12 rsp", 64'(ld_rsp_valid), 64'd0);
    @(negedge clk);
    do_load(A, 8'h01);                               // R12 empty: miss
    do_store(A, 64'h1111_1111_4433_2211, 8'h0F);     // R2
    do_store(A, 64'h8877_6655_2222_2222, 8'hF0);     // R4 merge
    do_load(A, 8'hFF);
    do_store(A, 64'h0000_00EE_DD00_0000, 8'h18);     // R5 overlap
    do_load(A, 8'hFF);
    do_store(A + 32'h28, 64'hA500_0000_0000_005A, 8'h81); // R6 word 5
    do_load(A + 32'h28, 8'h81);
    do_load(A + 32'h28, 8'hFF);                      // R8 partial -> miss
    do_load(A + 32'h28, 8'h81);                      // R8 unchanged
    do_load(A + 32'h10, 8'h01);
    repeat (5) tick();                               // R3 held
    do_store(A + 32'h40, 64'h0102_0304_0506_0708, 8'h3C);
    do_store(A + 32'h80, 64'hCAFE_F00D_DEAD_BEEF, 8'hFF);
    do_store(A + 32'hC0, 64'h1234_5678_9ABC_DEF0, 8'h01);
    hold_low = 3;
    do_store(A + 32'h100, 64'h5555_5555_5555_5555, 8'hAA); // R10 / R11
    check(evict_cnt == 1, "R10 one eviction", 64'(evict_cnt), 64'd1);
    rand_rdy = 1;
    do_flush();                                      // R9
    do_load(A + 32'h100, 8'h02);                     // R9 cleared -> miss
    for (int i = 0; i < 400; i++) begin
      int r;
      logic [31:0] a;
      r = int'($urandom % 10);
      a = 32'h2000 + 32'(($urandom % 6) * 64) + 32'(($urandom % 8) * 8);
      if (r < 6) begin
        logic [7:0] be;
        be = 8'($urandom);
        if (be == 0) be = 8'h10;
        st_valid = 1; st_word_addr = a[31:3]; st_data = {$urandom, $urandom}; st_be = be;
        if (r < 2) begin
          ld_valid = 1; ld_word_addr = a[31:3] ^ 29'h1; ld_be = 8'($urandom);
        end
        tick();
        ld_valid = 0;
        while (!st_fired) tick();
        st_valid = 0;
      end else if (r < 9) begin
        do_load(a, 8'($urandom));
      end else begin
        do_flush();
      end
    end
    do_flush();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule